// File: doc/BRIEF.md
# Configurable DDR/SDR Output Serializer

This block converts a parallel word into a serial bit stream on one output pin, together with a serial enable-control stream for the pin's driver. The fast clock sets the bit timing. The word boundary comes from an internal beat counter that divides the fast clock by the number of beats per word. The data path runs at single rate, with one bit per fast-clock cycle presented from the rising edge. It can also run at double rate, with two bits per cycle: the even bit is shown while the clock is high and the odd bit while it is low. Bits leave least significant first, one complete word per word period.

Parallel words arrive on a valid/ready handshake. `in_ready` is high only during the final beat of the word currently being sent, which is the load slot. A word is taken on the rising edge where `in_valid` and `in_ready` are both high, and it appears at the pin from that edge onward. The producer may raise `in_valid` early and hold it; nothing is taken before the slot. If no word is offered at the slot, an idle word goes out: data low with the driver disabled. Back-pressure therefore only ever stalls the producer. The pin never pauses.

The control path is selected by parameter. In pass-through mode it is unregistered. In registered mode it holds one bit per word. In double-rate mode it carries four bits per word, serialised in step with the data. Legal settings are checked at elaboration:
- Double-rate data accepts widths 4, 6, 8 and 10.
- Single-rate data accepts widths 2 to 8.
- A 4-bit control word is allowed only when both paths are double rate and the width is 4. Every other setting uses a 1-bit control word.

For 10-bit words, a slave lane holds the upper bits and feeds them into the master lane through cascade shift connections. Only the master drives the pin.

Top module: `ser_out_pin`

## Requirements
- R1: While `rst` is high at a rising edge, the block resets synchronously. Afterwards `ser_q` is 0, `in_ready` is 1, and `ser_t` is 1 in both registered control modes.
- R2: `in_ready` is 1 exactly in the last beat of each word period (beat index beats-per-word minus 1) and 0 in all other beats. A word offered while `in_ready` is 0 is not taken and does not disturb the word being sent.
- R3: In double-rate data mode, in beat k after the load edge, `ser_q` equals word bit 2k while the clock is high and bit 2k+1 while it is low. One word takes WORD_W/2 cycles.
- R4: In single-rate data mode, `ser_q` equals word bit k for the whole of beat k. One word takes WORD_W cycles.
- R5: If `in_valid` is 0 at a load slot, the next word period sends `ser_q` = 0, with `ser_t` = 1 in the registered control modes.
- R6: Words offered at consecutive load slots go out back to back, with no idle beat between them.
- R7: With a 4-bit control word in double-rate mode, `ser_t` follows control bits 2k (clock high) and 2k+1 (clock low) in beat k, in step with the data.
- R8: In single-rate registered control mode with a 1-bit control word, `ser_t` equals control bit 0 of the loaded word for the whole word period.
- R9: In pass-through control mode, `ser_t` equals `in_tri[0]` at all times, including during reset, with no register in the path.
- R10: For a 10-bit double-rate word, bits 8 and 9 come from the slave lane and follow bit 7 in beat 4, as bit 8 while the clock is high and bit 9 while it is low.
- R11: A reset in the middle of a word abandons that word. In the cycle after the reset edge, both clock phases show `ser_q` = 0 and `ser_t` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Load slot open (last beat of the current word) |
| in_data | input | WORD_W | Parallel data word, bit 0 sent first |
| in_tri | input | TRI_W | Parallel driver-control word, 1 = driver disabled |
| ser_q | output | 1 | Serial data to the pin |
| ser_t | output | 1 | Serial driver-control to the pin |

## Verification
The bench drives three configurations side by side: double-rate with a 4-bit control word, single-rate with a registered 1-bit control, and 10-bit cascaded with pass-through control.

It samples each clock phase separately. A swapped even/odd multiplexer therefore shows up as transposed bit pairs, and an off-by-one beat counter shows up as a shifted word or a missing beat between streamed words. A word offered early and held tests whether the load slot is respected; a design that loads on valid alone would cut the current word short.

Further checks go after three more corner cases:
- An empty slot must give a disabled, low pin. A design that repeats stale bits would fail this.
- A reset in mid-word must kill the word.
- In the 10-bit configuration, bits 8 and 9 must arrive from the slave in order. A wrong cascade direction would reorder them or return zeros.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

  typedef enum logic [1:0] {
    TRI_BUF = 2'd0,
    TRI_SDR = 2'd1,
    TRI_DDR = 2'd2
  } tri_mode_e;

  localparam int unsigned LANE_MAX_W = 8;

  function automatic bit cfg_ok(input bit data_ddr, input tri_mode_e tm,
                                input int unsigned w, input int unsigned tw);
    bit w_ok;
    bit tw_ok;
    if (data_ddr) w_ok = (w == 4) || (w == 6) || (w == 8) || (w == 10);
    else          w_ok = (w >= 2) && (w <= 8);
    if (tm == TRI_DDR && data_ddr && w == 4) tw_ok = (tw == 4);
    else                                     tw_ok = (tw == 1);
    return w_ok && tw_ok;
  endfunction

  function automatic int unsigned beat_bits(input bit data_ddr);
    return data_ddr ? 2 : 1;
  endfunction

endpackage

// File: rtl/ser_beat_ctrl.sv
module ser_beat_ctrl #(
  parameter int unsigned CPW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic ready_o,
  output logic take_o
);
  localparam int unsigned CNT_W = (CPW > 1) ? $clog2(CPW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CPW - 1);

  logic [CNT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst)               beat <= LAST;
    else if (beat == LAST) beat <= '0;
    else                   beat <= beat + 1'b1;
  end

  assign ready_o = (beat == LAST);
  assign take_o  = ready_o & in_valid;
endmodule

// File: rtl/ser_shift_lane.sv
module ser_shift_lane #(
  parameter int unsigned LANE_W = 4,
  parameter int unsigned STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              take_i,
  input  logic [LANE_W-1:0] word_i,
  input  logic [STEP-1:0]   casc_i,
  output logic [STEP-1:0]   low_o
);
  logic [LANE_W-1:0] sr;

  generate
    if (LANE_W > STEP) begin : g_deep
      always_ff @(posedge clk) begin
        if (rst)         sr <= '0;
        else if (load_i) sr <= take_i ? word_i : '0;
        else             sr <= {casc_i, sr[LANE_W-1:STEP]};
      end
    end else begin : g_flat
      always_ff @(posedge clk) begin
        if (rst)         sr <= '0;
        else if (load_i) sr <= take_i ? word_i : '0;
        else             sr <= casc_i;
      end
    end
  endgenerate

  assign low_o = sr[STEP-1:0];
endmodule

// File: rtl/ser_tri_path.sv
module ser_tri_path #(
  parameter ser_out_pkg::tri_mode_e TRI_MODE = ser_out_pkg::TRI_DDR,
  parameter int unsigned            TRI_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             take_i,
  input  logic [TRI_W-1:0] t_i,
  output logic             tq_o
);
  generate
    if (TRI_MODE == ser_out_pkg::TRI_BUF) begin : g_pass
      logic unused_pass;
      assign unused_pass = ^{clk, rst, load_i, take_i, t_i};
      assign tq_o = t_i[0];
    end else if (TRI_W == 4) begin : g_quad
      logic [3:0] ts;
      always_ff @(posedge clk) begin
        if (rst)         ts <= '1;
        else if (load_i) ts <= take_i ? t_i[3:0] : 4'hF;
        else             ts <= {2'b11, ts[3:2]};
      end
      assign tq_o = clk ? ts[0] : ts[1];
    end else begin : g_single
      logic ts1;
      always_ff @(posedge clk) begin
        if (rst)         ts1 <= 1'b1;
        else if (load_i) ts1 <= take_i ? t_i[0] : 1'b1;
      end
      assign tq_o = ts1;
    end
  endgenerate
endmodule

// File: rtl/ser_out_pin.sv
module ser_out_pin #(
  parameter bit                     DATA_DDR = 1'b1,
  parameter ser_out_pkg::tri_mode_e TRI_MODE = ser_out_pkg::TRI_DDR,
  parameter int unsigned            WORD_W   = 4,
  parameter int unsigned            TRI_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [TRI_W-1:0]  in_tri,
  output logic              ser_q,
  output logic              ser_t
);
  localparam int unsigned STEP = ser_out_pkg::beat_bits(DATA_DDR);
  localparam int unsigned CPW  = WORD_W / STEP;
  localparam int unsigned MW   = (WORD_W > ser_out_pkg::LANE_MAX_W) ?
                                 ser_out_pkg::LANE_MAX_W : WORD_W;
  localparam int unsigned SW   = WORD_W - MW;

  if (!ser_out_pkg::cfg_ok(DATA_DDR, TRI_MODE, WORD_W, TRI_W)) begin : g_bad_cfg
    $error("ser_out_pin: illegal combination of rate modes and widths");
  end

  logic            take;
  logic [STEP-1:0] casc;
  logic [STEP-1:0] low;

  ser_beat_ctrl #(.CPW(CPW)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .ready_o  (in_ready),
    .take_o   (take)
  );

  generate
    if (SW > 0) begin : g_slave
      ser_shift_lane #(.LANE_W(SW), .STEP(STEP)) u_slave (
        .clk    (clk),
        .rst    (rst),
        .load_i (in_ready),
        .take_i (take),
        .word_i (in_data[WORD_W-1:MW]),
        .casc_i ({STEP{1'b0}}),
        .low_o  (casc)
      );
    end else begin : g_solo
      assign casc = '0;
    end
  endgenerate

  ser_shift_lane #(.LANE_W(MW), .STEP(STEP)) u_master (
    .clk    (clk),
    .rst    (rst),
    .load_i (in_ready),
    .take_i (take),
    .word_i (in_data[MW-1:0]),
    .casc_i (casc),
    .low_o  (low)
  );

  generate
    if (DATA_DDR) begin : g_ddr_mux
      assign ser_q = clk ? low[0] : low[STEP-1];
    end else begin : g_sdr_out
      assign ser_q = low[0];
    end
  endgenerate

  ser_tri_path #(.TRI_MODE(TRI_MODE), .TRI_W(TRI_W)) u_tri (
    .clk    (clk),
    .rst    (rst),
    .load_i (in_ready),
    .take_i (take),
    .t_i    (in_tri),
    .tq_o   (ser_t)
  );
endmodule

// File: rtl/ser_out_pin_chk.sv
module ser_out_pin_chk #(
  parameter bit                     DATA_DDR = 1'b1,
  parameter ser_out_pkg::tri_mode_e TRI_MODE = ser_out_pkg::TRI_DDR,
  parameter int unsigned            WORD_W   = 4,
  parameter int unsigned            TRI_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [TRI_W-1:0] in_tri,
  input logic             ser_q,
  input logic             ser_t
);
  localparam int unsigned CPW   = WORD_W / ser_out_pkg::beat_bits(DATA_DDR);
  localparam int unsigned GAP_W = $clog2(CPW) + 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CPW - 1);

  logic [GAP_W-1:0] gap;
  logic             unused_chk;
  assign unused_chk = ^in_tri;

  always_ff @(posedge clk) begin
    if (rst)                  gap <= GAP_LAST;
    else if (gap == GAP_LAST) gap <= '0;
    else                      gap <= gap + 1'b1;
  end

  AST_RESET_READY: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> in_ready); // R1
  AST_SLOT_PERIOD: assert property (@(posedge clk) disable iff (rst) in_ready == (gap == GAP_LAST)); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) (in_ready && !in_valid) |=> !ser_q); // R5

  generate
    if (TRI_MODE == ser_out_pkg::TRI_BUF) begin : g_pass_chk
      AST_BUF_PASS: assert property (@(posedge clk) disable iff (rst) ser_t == in_tri[0]); // R9
    end else begin : g_reg_chk
      AST_IDLE_DISABLE: assert property (@(posedge clk) disable iff (rst) (in_ready && !in_valid) |=> ser_t); // R5
      if (TRI_W == 1) begin : g_hold_chk
        AST_TRI_HOLD: assert property (@(posedge clk) disable iff (rst) !in_ready |=> $stable(ser_t)); // R8
      end
    end
  endgenerate
endmodule

bind ser_out_pin ser_out_pin_chk #(
  .DATA_DDR (DATA_DDR),
  .TRI_MODE (TRI_MODE),
  .WORD_W   (WORD_W),
  .TRI_W    (TRI_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_tri   (in_tri),
  .ser_q    (ser_q),
  .ser_t    (ser_t)
);

// File: tb/test_ser_out_pin.sv
`timescale 1ns/100ps
module test_ser_out_pin;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // A: double-rate data, 4-bit word, 4-bit double-rate control
  logic a_valid = 1'b0, a_ready, a_q, a_t;
  logic [3:0] a_data = '0, a_tri = '0;
  // B: single-rate data, 6-bit word, registered 1-bit control
  logic b_valid = 1'b0, b_ready, b_q, b_t;
  logic [5:0] b_data = '0;
  logic [0:0] b_tri = '0;
  // C: double-rate data, 10-bit cascaded word, pass-through control
  logic c_valid = 1'b0, c_ready, c_q, c_t;
  logic [9:0] c_data = '0;
  logic [0:0] c_tri = '0;

  ser_out_pin i_ser_out_pin (
    .clk(clk), .rst(rst), .in_valid(a_valid), .in_ready(a_ready),
    .in_data(a_data), .in_tri(a_tri), .ser_q(a_q), .ser_t(a_t));

  ser_out_pin #(.DATA_DDR(1'b0), .TRI_MODE(ser_out_pkg::TRI_SDR), .WORD_W(6), .TRI_W(1))
  i_ser_out_pin_sdr (
    .clk(clk), .rst(rst), .in_valid(b_valid), .in_ready(b_ready),
    .in_data(b_data), .in_tri(b_tri), .ser_q(b_q), .ser_t(b_t));

  ser_out_pin #(.DATA_DDR(1'b1), .TRI_MODE(ser_out_pkg::TRI_BUF), .WORD_W(10), .TRI_W(1))
  i_ser_out_pin_wide (
    .clk(clk), .rst(rst), .in_valid(c_valid), .in_ready(c_ready),
    .in_data(c_data), .in_tri(c_tri), .ser_q(c_q), .ser_t(c_t));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    c_tri = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 a_q", a_q, 0);   check("R1 a_t", a_t, 1);   check("R1 a_ready", a_ready, 1);
    check("R1 b_q", b_q, 0);   check("R1 b_t", b_t, 1);   check("R1 b_ready", b_ready, 1);
    check("R1 c_q", c_q, 0);   check("R1 c_ready", c_ready, 1);
    check("R9 c_t in reset", c_t, 1);
    c_tri = 1'b0;
    #0.5;
    check("R9 c_t follows in reset", c_t, 0);
    #1.5;
    check("R1 a_q low phase", a_q, 0);
    rst = 1'b0;
  endtask

  task automatic run_a(input logic [3:0] d, input logic [3:0] t, input string tag0);
    while (!a_ready) begin @(posedge clk); #3; end
    a_valid = 1'b1; a_data = d; a_tri = t;
    @(posedge clk); #1;
    a_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      check("R2 a_ready", a_ready, (k == 1));
      check((k == 0) ? tag0 : "R3 a_q high", a_q, d[2*k]);
      check("R7 a_t high", a_t, t[2*k]);
      #2;
      check("R3 a_q low", a_q, d[2*k+1]);
      check("R7 a_t low", a_t, t[2*k+1]);
      if (k == 0) begin @(posedge clk); #1; end
    end
  endtask

  task automatic a_idle();
    a_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      check("R5 a_q idle high", a_q, 0); check("R5 a_t idle high", a_t, 1);
      #2;
      check("R5 a_q idle low", a_q, 0);  check("R5 a_t idle low", a_t, 1);
    end
  endtask

  task automatic a_reset_mid();
    while (!a_ready) begin @(posedge clk); #3; end
    a_valid = 1'b1; a_data = 4'hF; a_tri = 4'h0;
    @(posedge clk); #1;
    a_valid = 1'b0;
    check("R3 a_q before reset", a_q, 1);
    #2;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11 a_q high", a_q, 0); check("R11 a_t high", a_t, 1); check("R11 a_ready", a_ready, 1);
    #2;
    check("R11 a_q low", a_q, 0);  check("R11 a_t low", a_t, 1);
    rst = 1'b0;
  endtask

  task automatic run_b(input logic [5:0] d, input logic t, input bit hold,
                       input logic [5:0] nd, input logic nt, input string tag0);
    while (!b_ready) begin @(posedge clk); #3; end
    b_valid = 1'b1; b_data = d; b_tri = t;
    @(posedge clk); #1;
    b_valid = hold; b_data = nd; b_tri = nt;
    for (int k = 0; k < 6; k++) begin
      check("R2 b_ready", b_ready, (k == 5));
      check((k == 0) ? tag0 : "R4 b_q high", b_q, d[k]);
      check("R8 b_t high", b_t, t);
      #2;
      check("R4 b_q low", b_q, d[k]);
      check("R8 b_t low", b_t, t);
      if (k < 5) begin @(posedge clk); #1; end
    end
  endtask

  task automatic run_c(input logic [9:0] d);
    while (!c_ready) begin @(posedge clk); #3; end
    c_valid = 1'b1; c_data = d;
    @(posedge clk); #1;
    c_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check((k == 4) ? "R10 c_q high" : "R3 c_q high", c_q, d[2*k]);
      check("R9 c_t high", c_t, c_tri[0]);
      c_tri = ~c_tri;
      #2;
      check((k == 4) ? "R10 c_q low" : "R3 c_q low", c_q, d[2*k+1]);
      check("R9 c_t low", c_t, c_tri[0]);
      if (k < 4) begin @(posedge clk); #1; end
    end
  endtask

  initial begin
    t_reset();
    run_a(4'b1011, 4'b0110, "R3 a_q first");
    run_a(4'b0100, 4'b1001, "R6 a_q streamed");
    a_idle();
    a_reset_mid();
    run_a(4'b1110, 4'b0011, "R3 a_q after reset");
    run_b(6'b101101, 1'b1, 1'b1, 6'b010011, 1'b0, "R4 b_q first");
    run_b(6'b010011, 1'b0, 1'b0, 6'b000000, 1'b0, "R6 b_q streamed");
    run_c(10'b10_1011_0110);
    run_c(10'b01_0100_1001);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule